// File: doc/BRIEF.md
# Per-Lane Selectable Event Counter

This block holds one counter for a serial link's statistics logic. Out of a large vector of single-cycle event strobes, laid out by event group, event number and lane, it counts the one strobe that software has selected. Software reaches the block through two 32-bit words. The control word at offset 0x8 carries the selector, the lane, a coded run command and a coded clear command, and it reports back whether the counter is running. The count word at offset 0xC returns the running total.

The count is never reset implicitly. Software zeros it with a clear command, either before it switches the counter on or in the same write. The count wraps silently at its width and raises no interrupt. The selector is twelve bits wide: a 4-bit group in the upper part and an 8-bit event number in the lower part. For example, code 0x600 in group 6 counts transmitted acknowledge packets, and code 0x70C in group 7 counts received memory reads. The strobe vector is sized by parameters. Any selection that falls outside that size simply never counts.

Top module: `lec_lane_counter`

## Requirements
- R1: After reset the counter is stopped, the count reads 0, and the control word reads 0.
- R2: Every write to offset 0x8 loads the group from bits 27:24, the event number from bits 23:16 and the lane from bits 11:8. A read of offset 0x8 returns these fields at the same positions and bit 7 as the running status. All other bits read 0, including the command fields.
- R3: Run command bits 4:2 = 3'b011 start counting and 3'b001 stop it. The new state applies from the clock after the write, so a strobe in the write cycle uses the old state. Bit 7 of the control word reads 1 while counting.
- R4: Any other run command value (0, 2, 4 to 7) leaves the running state as it was.
- R5: Clear command bits 1:0 = 2'b01 zero the count, and a strobe in that cycle is lost. Values 0, 2 and 3 do not clear. A clear combined with a stop leaves the count at 0 and stopped. A clear combined with a start counts from 0.
- R6: While running, the count adds one for each clock in which strobe ((group*EVT_PER_GRP)+event)*LANES+lane is high. No other strobe counts. The count grows by at most one per clock.
- R7: A selection whose group is at least GROUPS, whose event is at least EVT_PER_GRP, or whose lane is at least LANES never counts.
- R8: A stopped counter holds its value. Stopping and restarting does not clear it.
- R9: Changing the selector or the lane while running does not alter the count. Counting continues on the new selection.
- R10: Offset 0xC returns the count, zero-extended, and the count wraps modulo 2^CNT_W.
- R11: Writes to offset 0xC or to unmapped offsets change nothing. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte offset of the combinational read |
| rd_data | output | 32 | Read data |
| evt_strobe | input | GROUPS*EVT_PER_GRP*LANES | Event strobes, one per group/event/lane |

## Verification
The hardest situations to reach are those where a command write and the selected strobe fall in the same clock. Whether that strobe is counted depends on the running state before the write, and a clear always wins. The bench drives the write and the strobe together from one task, so these edges are hit deliberately for start, stop and clear.

Wrap-around cannot be reached at 32 bits within the run. A second instance with a 4-bit count shares every input, so both totals can be compared after a long burst. Isolation is shown by raising every strobe except the selected one, and then all of them at once.

// File: rtl/lec_pkg.sv
package lec_pkg;

   localparam int unsigned REG_W      = 32;
   localparam int unsigned GRP_W      = 4;
   localparam int unsigned EVT_W      = 8;
   localparam int unsigned LANE_W     = 4;

   // control word bit positions
   localparam int unsigned GRP_LSB    = 24;
   localparam int unsigned EVT_LSB    = 16;
   localparam int unsigned LANE_LSB   = 8;
   localparam int unsigned RUN_BIT    = 7;
   localparam int unsigned ENA_LSB    = 2;
   localparam int unsigned CLR_LSB    = 0;

   // command codes
   localparam logic [2:0] ENA_START  = 3'b011;
   localparam logic [2:0] ENA_STOP   = 3'b001;
   localparam logic [1:0] CLR_GO     = 2'b01;

   typedef struct packed {
      logic [GRP_W-1:0]  grp;
      logic [EVT_W-1:0]  evt;
      logic [LANE_W-1:0] lane;
   } sel_t;

   function automatic logic [REG_W-1:0] pack_ctrl(input sel_t s, input logic run);
      logic [REG_W-1:0] w;
      w = '0;
      w[GRP_LSB  +: GRP_W]  = s.grp;
      w[EVT_LSB  +: EVT_W]  = s.evt;
      w[LANE_LSB +: LANE_W] = s.lane;
      w[RUN_BIT]            = run;
      return w;
   endfunction

   function automatic sel_t unpack_sel(input logic [REG_W-1:0] w);
      sel_t s;
      s.grp  = w[GRP_LSB  +: GRP_W];
      s.evt  = w[EVT_LSB  +: EVT_W];
      s.lane = w[LANE_LSB +: LANE_W];
      return s;
   endfunction

endpackage

// File: rtl/lec_ctrl_regs.sv
module lec_ctrl_regs
   import lec_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic [REG_W-1:0] wr_data,
   output sel_t             sel_o,
   output logic             run_o,
   output logic             clr_o
);

   logic [2:0] ena_cmd;
   logic [1:0] clr_cmd;
   sel_t       sel_q;
   logic       run_q;
   logic       unused_bits;

   assign ena_cmd     = wr_data[ENA_LSB +: 3];
   assign clr_cmd     = wr_data[CLR_LSB +: 2];
   assign unused_bits = ^{wr_data[31:28], wr_data[15:12], wr_data[7:5]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         run_q <= 1'b0;
      end else if (ctrl_wr) begin
         sel_q <= unpack_sel(wr_data);
         if (ena_cmd == ENA_START)
            run_q <= 1'b1;
         else if (ena_cmd == ENA_STOP)
            run_q <= 1'b0;
      end
   end

   assign sel_o = sel_q;
   assign run_o = run_q;
   assign clr_o = ctrl_wr && (clr_cmd == CLR_GO);

   // R3: start / stop commands land on the next clock
   a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wr_data[4:2] == 3'b011) |=> run_o);
   a_r3_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wr_data[4:2] == 3'b001) |=> !run_o);
   // R4: undefined run codes keep the state
   a_r4_keep_run: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wr_data[4:2] != 3'b011 && wr_data[4:2] != 3'b001) |=> $stable(run_o));
   // R2: selector fields only move on a control write
   a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(sel_o));

endmodule

// File: rtl/lec_event_sel.sv
module lec_event_sel
   import lec_pkg::*;
#(
   parameter int unsigned GROUPS      = 8,
   parameter int unsigned EVT_PER_GRP = 24,
   parameter int unsigned LANES       = 4,
   parameter bit          REG_STROBE  = 1'b0,
   localparam int unsigned NUM_STB    = GROUPS * EVT_PER_GRP * LANES,
   localparam int unsigned IDX_W      = (NUM_STB > 1) ? $clog2(NUM_STB) : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  sel_t               sel_i,
   input  logic [NUM_STB-1:0] evt_strobe,
   output logic               hit_o
);

   logic [31:0]      flat_idx;
   logic [IDX_W-1:0] idx;
   logic             in_range;
   logic             raw_hit;

   always_comb begin
      in_range = (32'(sel_i.grp)  < GROUPS) &&
                 (32'(sel_i.evt)  < EVT_PER_GRP) &&
                 (32'(sel_i.lane) < LANES);
      flat_idx = ((32'(sel_i.grp) * EVT_PER_GRP) + 32'(sel_i.evt)) * LANES
                 + 32'(sel_i.lane);
      idx      = in_range ? IDX_W'(flat_idx) : '0;
      raw_hit  = in_range && evt_strobe[idx];
   end

   generate
      if (REG_STROBE) begin : g_reg
         logic hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= raw_hit;
         end
         assign hit_o = hit_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign hit_o = raw_hit;
      end
   endgenerate

   // R7: selections past the strobe vector never produce a hit
   a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
      !in_range |-> !raw_hit);

endmodule

// File: rtl/lec_count_core.sv
module lec_count_core #(
   parameter int unsigned CNT_W = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic             hit_i,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr_i)
         cnt_q <= '0;
      else if (run_i && hit_i)
         cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R5: clear empties the counter on the next clock
   a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_o == '0));
   // R6: at most one step per clock, modulo the width
   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));
   // R8: a stopped counter holds
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !run_i) |=> $stable(cnt_o));

endmodule

// File: rtl/lec_lane_counter.sv
module lec_lane_counter
   import lec_pkg::*;
#(
   parameter int unsigned GROUPS      = 8,
   parameter int unsigned EVT_PER_GRP = 24,
   parameter int unsigned LANES       = 4,
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned CTRL_OFS    = 8'h08,
   parameter int unsigned DATA_OFS    = 8'h0C,
   parameter bit          REG_STROBE  = 1'b0,
   localparam int unsigned NUM_STB    = GROUPS * EVT_PER_GRP * LANES
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [31:0]        wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [31:0]        rd_data,
   input  logic [NUM_STB-1:0] evt_strobe
);

   // elaboration-time parameter checks
   generate
      if (GROUPS < 1 || GROUPS > (1 << GRP_W)) begin : g_bad_grp
         $error("GROUPS out of range");
      end
      if (EVT_PER_GRP < 1 || EVT_PER_GRP > (1 << EVT_W)) begin : g_bad_evt
         $error("EVT_PER_GRP out of range");
      end
      if (LANES < 1 || LANES > (1 << LANE_W)) begin : g_bad_lane
         $error("LANES out of range");
      end
      if (CNT_W < 1 || CNT_W > REG_W) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (CTRL_OFS == DATA_OFS || (CTRL_OFS % 4) != 0 || (DATA_OFS % 4) != 0) begin : g_bad_ofs
         $error("register offsets must differ and be word aligned");
      end
      if (CTRL_OFS >= (1 << ADDR_W) || DATA_OFS >= (1 << ADDR_W)) begin : g_bad_aw
         $error("ADDR_W too narrow for offsets");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

   logic             ctrl_wr;
   sel_t             sel;
   logic             run;
   logic             clr;
   logic             hit;
   logic [CNT_W-1:0] cnt;

   assign ctrl_wr = wr_en && (wr_addr == CTRL_A);

   lec_ctrl_regs u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_wr (ctrl_wr),
      .wr_data (wr_data),
      .sel_o   (sel),
      .run_o   (run),
      .clr_o   (clr)
   );

   lec_event_sel #(
      .GROUPS      (GROUPS),
      .EVT_PER_GRP (EVT_PER_GRP),
      .LANES       (LANES),
      .REG_STROBE  (REG_STROBE)
   ) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (sel),
      .evt_strobe (evt_strobe),
      .hit_o      (hit)
   );

   lec_count_core #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr),
      .run_i (run),
      .hit_i (hit),
      .cnt_o (cnt)
   );

   always_comb begin
      if (rd_addr == CTRL_A)
         rd_data = pack_ctrl(sel, run);
      else if (rd_addr == DATA_A)
         rd_data = REG_W'(cnt);
      else
         rd_data = '0;
   end

   // R11: unmapped reads return zero
   a_r11_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr != CTRL_A && rd_addr != DATA_A) |-> (rd_data == 32'h0));
   // R11: writes outside the control word leave the selector alone
   a_r11_no_side: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != CTRL_A) |=> $stable(rd_data[27:8]) || $past(rd_addr) != rd_addr);

endmodule

// File: tb/sim_lec_lane_counter.sv
module sim_lec_lane_counter;

   localparam int G  = 8;
   localparam int E  = 24;
   localparam int L  = 4;
   localparam int NS = G * E * L;
   localparam logic [7:0] A_CTRL = 8'h08;
   localparam logic [7:0] A_DATA = 8'h0C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [7:0]    rd_addr = '0;
   logic [31:0]   rd_data;
   logic [31:0]   rd_data_s;
   logic [NS-1:0] strobes = '0;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   lec_lane_counter u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .evt_strobe(strobes)
   );

   lec_lane_counter #(.CNT_W(4)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_s),
      .evt_strobe(strobes)
   );

   function automatic int sidx(int g, int e, int l);
      return ((g * E) + e) * L + l;
   endfunction

   function automatic logic [31:0] cw(int g, int e, int l, int en, int cl);
      return (32'(g) << 24) | (32'(e) << 16) | (32'(l) << 8) | (32'(en) << 2) | 32'(cl);
   endfunction

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(int i, int n);
      @(negedge clk);
      strobes = '0; strobes[i] = 1'b1;
      repeat (n) @(negedge clk);
      strobes = '0;
   endtask

   task automatic cmd_and_pulse(logic [31:0] d, int i);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = A_CTRL; wr_data = d;
      strobes = '0; strobes[i] = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; strobes = '0;
   endtask

   function automatic logic [31:0] count_now();
      return 32'(u0.rd_data);
   endfunction

   task automatic rd_cnt(output logic [31:0] v);
      rd(A_DATA, v);
   endtask

   task automatic rd_run(output logic [31:0] v);
      logic [31:0] t;
      rd(A_CTRL, t);
      v = {31'b0, t[7]};
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_CTRL, v); chk("R1 ctrl after reset", v, 32'h0);
      rd_cnt(v);     chk("R1 count after reset", v, 32'h0);
   endtask

   task automatic t_fields();
      logic [31:0] v;
      wr(A_CTRL, cw(7, 8'h0C, 3, 0, 2));
      rd(A_CTRL, v); chk("R2 fields 0x70C lane3", v, 32'h070C_0300);
      wr(A_CTRL, 32'hF5AB_FFE0 & ~32'h0000_001C | cw(5, 8'hAB, 15, 0, 0));
      rd(A_CTRL, v); chk("R2 fields masked", v, 32'h05AB_0F00);
   endtask

   task automatic t_count();
      logic [31:0] v;
      wr(A_CTRL, cw(6, 0, 1, 3, 1));
      rd_run(v); chk("R3 running status", v, 1);
      rd(A_CTRL, v); chk("R2 ctrl with run", v, 32'h0600_0180);
      rd_cnt(v); chk("R5 start+clear from zero", v, 0);
      pulse(sidx(6, 0, 1), 5);
      rd_cnt(v); chk("R6 five strobes", v, 5);
   endtask

   task automatic t_edges();
      logic [31:0] v;
      cmd_and_pulse(cw(6, 0, 1, 1, 0), sidx(6, 0, 1));
      rd_cnt(v); chk("R3 strobe in stop cycle counted", v, 6);
      rd_run(v); chk("R3 stopped status", v, 0);
      pulse(sidx(6, 0, 1), 3);
      rd_cnt(v); chk("R8 stopped holds", v, 6);
      cmd_and_pulse(cw(6, 0, 1, 3, 0), sidx(6, 0, 1));
      rd_cnt(v); chk("R3 strobe in start cycle ignored", v, 6);
      pulse(sidx(6, 0, 1), 2);
      rd_cnt(v); chk("R8 restart keeps count", v, 8);
   endtask

   task automatic t_illegal();
      logic [31:0] v;
      wr(A_CTRL, cw(6, 0, 1, 0, 0));
      rd_run(v); chk("R4 code 0 keeps running", v, 1);
      pulse(sidx(6, 0, 1), 1);
      rd_cnt(v); chk("R4 still counting", v, 9);
      wr(A_CTRL, cw(6, 0, 1, 1, 0));
      wr(A_CTRL, cw(6, 0, 1, 2, 0));
      rd_run(v); chk("R4 code 2 keeps stopped", v, 0);
      wr(A_CTRL, cw(6, 0, 1, 4, 0));
      wr(A_CTRL, cw(6, 0, 1, 7, 0));
      rd_run(v); chk("R4 codes 4,7 keep stopped", v, 0);
      pulse(sidx(6, 0, 1), 2);
      rd_cnt(v); chk("R4 no counting", v, 9);
   endtask

   task automatic t_clear();
      logic [31:0] v;
      wr(A_CTRL, cw(6, 0, 1, 3, 2));
      rd_cnt(v); chk("R5 clear code 2 ignored", v, 9);
      wr(A_CTRL, cw(6, 0, 1, 3, 3));
      rd_cnt(v); chk("R5 clear code 3 ignored", v, 9);
      wr(A_CTRL, cw(6, 0, 1, 1, 1));
      rd_cnt(v); chk("R5 clear+stop zeros", v, 0);
      rd_run(v); chk("R5 clear+stop stopped", v, 0);
      pulse(sidx(6, 0, 1), 2);
      rd_cnt(v); chk("R5 stays zero", v, 0);
      cmd_and_pulse(cw(6, 0, 1, 3, 1), sidx(6, 0, 1));
      rd_cnt(v); chk("R5 start+clear with strobe", v, 0);
      pulse(sidx(6, 0, 1), 4);
      cmd_and_pulse(cw(6, 0, 1, 3, 1), sidx(6, 0, 1));
      rd_cnt(v); chk("R5 clear beats strobe", v, 0);
      pulse(sidx(6, 0, 1), 1);
      rd_cnt(v); chk("R5 counts after clear", v, 1);
   endtask

   task automatic t_isolation();
      logic [31:0] v;
      wr(A_CTRL, cw(7, 8'h0C, 2, 3, 1));
      @(negedge clk);
      strobes = '1; strobes[sidx(7, 8'h0C, 2)] = 1'b0;
      repeat (10) @(negedge clk);
      strobes = '0;
      rd_cnt(v); chk("R6 others ignored", v, 0);
      @(negedge clk);
      strobes = '1;
      repeat (3) @(negedge clk);
      strobes = '0;
      rd_cnt(v); chk("R6 one per clock", v, 3);
   endtask

   task automatic t_range();
      logic [31:0] v;
      wr(A_CTRL, cw(3, 24, 0, 3, 1));
      @(negedge clk); strobes = '1; repeat (5) @(negedge clk); strobes = '0;
      rd_cnt(v); chk("R7 event out of range", v, 0);
      wr(A_CTRL, cw(3, 0, 4, 3, 1));
      @(negedge clk); strobes = '1; repeat (5) @(negedge clk); strobes = '0;
      rd_cnt(v); chk("R7 lane out of range", v, 0);
      wr(A_CTRL, cw(8, 0, 0, 3, 1));
      @(negedge clk); strobes = '1; repeat (5) @(negedge clk); strobes = '0;
      rd_cnt(v); chk("R7 group out of range", v, 0);
   endtask

   task automatic t_selchange();
      logic [31:0] v;
      wr(A_CTRL, cw(0, 0, 0, 3, 1));
      pulse(sidx(0, 0, 0), 4);
      wr(A_CTRL, cw(1, 2, 3, 0, 0));
      rd_cnt(v); chk("R9 reselect keeps count", v, 4);
      pulse(sidx(1, 2, 3), 2);
      rd_cnt(v); chk("R9 new selection counts", v, 6);
      pulse(sidx(0, 0, 0), 2);
      rd_cnt(v); chk("R9 old selection ignored", v, 6);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr(A_DATA, 32'hFFFF_FFFF);
      rd_cnt(v); chk("R11 data write ignored", v, 6);
      wr(8'h10, cw(5, 1, 1, 1, 1));
      rd_cnt(v); chk("R11 unmapped write count", v, 6);
      rd(A_CTRL, v); chk("R11 unmapped write ctrl", v, 32'h0102_0380);
      rd(8'h04, v); chk("R11 unmapped read", v, 0);
   endtask

   task automatic t_wrap();
      logic [31:0] v;
      wr(A_CTRL, cw(0, 1, 0, 3, 1));
      pulse(sidx(0, 1, 0), 18);
      rd_cnt(v); chk("R10 wide count", v, 18);
      rd_addr = A_DATA; #1;
      chk("R10 narrow wraps", rd_data_s, 2);
   endtask

   initial begin
      #(20 * 100000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fields();
      t_count();
      t_edges();
      t_illegal();
      t_clear();
      t_isolation();
      t_range();
      t_selchange();
      t_unmapped();
      t_wrap();
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule